// File: doc/BRIEF.md
# Nibble ALU with Output Inversion

This block is a purely combinational arithmetic and logic unit working on two
operands of a parameterised width, four bits by default. An arithmetic group
offers wrapping addition, wrapping subtraction and one-place rotation of the
first operand in either direction. A logic group offers four bitwise functions
of both operands.

A single pick control routes one group's result forward. A final invert control
can complement that result bit by bit before it reaches the output. The
operation codes are fixed, so a decoder upstream can drive the selects directly.
There is no clock inside the block, and the output follows the inputs as soon as
they settle.

Top module: `nibble_alu`

## Requirements
- R1: The block has no state, and `y_out` follows any input change within the same cycle without a clock edge.
- R2: With `arith_op` = 0, the arithmetic result is `a_in + b_in` modulo 2^WIDTH, and the carry is dropped.
- R3: With `arith_op` = 1, the arithmetic result is `a_in - b_in` modulo 2^WIDTH, and the borrow is dropped.
- R4: With `arith_op` = 2, the arithmetic result is `a_in` rotated left by one place, and the top bit of `a_in` lands in bit 0.
- R5: With `arith_op` = 3, the arithmetic result is `a_in` rotated right by one place, and bit 0 of `a_in` lands in the top bit.
- R6: With `logic_op` = 0, the logic result is the bitwise AND of the operands. With `logic_op` = 1, it is the bitwise OR.
- R7: With `logic_op` = 2, the logic result is the bitwise XOR of the operands. With `logic_op` = 3, it is the bitwise XNOR.
- R8: `pick_logic` = 0 forwards the arithmetic result and `pick_logic` = 1 forwards the logic result. The select of the group that is not picked has no effect on `y_out`.
- R9: With `invert_out` = 1, `y_out` is the bitwise complement of the forwarded result. With `invert_out` = 0, `y_out` is that result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH (4) | First operand, also the rotation source |
| b_in | input | WIDTH (4) | Second operand |
| arith_op | input | 2 | Arithmetic function code |
| logic_op | input | 2 | Bitwise function code |
| pick_logic | input | 1 | 0 forwards arithmetic, 1 forwards logic |
| invert_out | input | 1 | Complements the forwarded result |
| y_out | output | WIDTH (4) | Result |

## Verification
Directed vectors test the wrap points: all-ones plus one, zero minus one, and
rotation of values with only the top bit or only bit 0 set. These vectors show
whether the carry is dropped and whether a rotation is mistaken for a shift.
Pairs of vectors change only the select of the group that is not picked, which
shows whether the selects leak into the output. A seeded random sweep covers
every code combination with and without inversion. It tells apart functions that
agree on easy operands, such as OR and XOR, or add and subtract with `b_in` = 0.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      AR_ADD = 2'd0,
      AR_SUB = 2'd1,
      AR_ROL = 2'd2,
      AR_ROR = 2'd3
   } arith_op_e;

   typedef enum logic [OP_W-1:0] {
      LG_AND  = 2'd0,
      LG_OR   = 2'd1,
      LG_XOR  = 2'd2,
      LG_XNOR = 2'd3
   } logic_op_e;
endpackage

// File: rtl/nalu_arith.sv
module nalu_arith #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0]    a,
   input  logic [WIDTH-1:0]    b,
   input  nalu_pkg::arith_op_e op,
   output logic [WIDTH-1:0]    res
);
   import nalu_pkg::*;

   logic [WIDTH-1:0] sum_w, dif_w, rol_w, ror_w;

   assign sum_w = a + b;
   assign dif_w = a - b;
   assign rol_w = {a[WIDTH-2:0], a[WIDTH-1]};
   assign ror_w = {a[0], a[WIDTH-1:1]};

   always_comb begin
      case (op)
         AR_ADD:  res = sum_w;
         AR_SUB:  res = dif_w;
         AR_ROL:  res = rol_w;
         default: res = ror_w;
      endcase
   end

   always_comb begin
      if (op == AR_ADD) begin
         p_add_undo_r2: assert ((res - b) == a);
      end
      if (op == AR_SUB) begin
         p_sub_undo_r3: assert ((res + b) == a);
      end
      if (op == AR_ROL) begin
         p_rol_wrap_r4: assert (res[0] == a[WIDTH-1] && $countones(res) == $countones(a));
      end
      if (op == AR_ROR) begin
         p_ror_wrap_r5: assert (res[WIDTH-1] == a[0] && $countones(res) == $countones(a));
      end
   end
endmodule

// File: rtl/nalu_logic.sv
module nalu_logic #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0]    a,
   input  logic [WIDTH-1:0]    b,
   input  nalu_pkg::logic_op_e op,
   output logic [WIDTH-1:0]    res
);
   import nalu_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         case (op)
            LG_AND:  res[i] = a[i] & b[i];
            LG_OR:   res[i] = a[i] | b[i];
            LG_XOR:  res[i] = a[i] ^ b[i];
            default: res[i] = ~(a[i] ^ b[i]);
         endcase
      end
   end

   always_comb begin
      if (op == LG_AND) begin
         p_and_subset_r6: assert ((res & ~a) == '0 && (res & ~b) == '0);
      end
      if (op == LG_OR) begin
         p_or_superset_r6: assert ((a & ~res) == '0 && (b & ~res) == '0);
      end
      if (op == LG_XOR) begin
         p_xor_zero_r7: assert ($countones(res ^ a ^ b) == 0);
      end
      if (op == LG_XNOR) begin
         p_xnor_ones_r7: assert ($countones(res ^ a ^ b) == WIDTH);
      end
   end
endmodule

// File: rtl/nalu_outsel.sv
module nalu_outsel #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] arith_res,
   input  logic [WIDTH-1:0] logic_res,
   input  logic             pick_logic,
   input  logic             invert,
   output logic [WIDTH-1:0] y
);
   logic [WIDTH-1:0] chosen;

   assign chosen = pick_logic ? logic_res : arith_res;

   for (genvar i = 0; i < WIDTH; i++) begin : g_inv
      assign y[i] = chosen[i] ^ invert;
   end

   always_comb begin
      if (!pick_logic && !invert) begin
         p_pick_arith_r8: assert (y == arith_res);
      end
      if (pick_logic && !invert) begin
         p_pick_logic_r8: assert (y == logic_res);
      end
      if (!pick_logic && invert) begin
         p_inv_arith_r9: assert ($countones(y ^ arith_res) == WIDTH);
      end
      if (pick_logic && invert) begin
         p_inv_logic_r9: assert ($countones(y ^ logic_res) == WIDTH);
      end
   end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [1:0]       arith_op,
   input  logic [1:0]       logic_op,
   input  logic             pick_logic,
   input  logic             invert_out,
   output logic [WIDTH-1:0] y_out
);
   import nalu_pkg::*;

   if (WIDTH < 2) begin : g_bad_width
      $error("nibble_alu: WIDTH must be at least 2 for rotation");
   end

   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] logic_res;

   nalu_arith #(.WIDTH(WIDTH)) u_arith (
      .a   (a_in),
      .b   (b_in),
      .op  (arith_op_e'(arith_op)),
      .res (arith_res)
   );

   nalu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (a_in),
      .b   (b_in),
      .op  (logic_op_e'(logic_op)),
      .res (logic_res)
   );

   nalu_outsel #(.WIDTH(WIDTH)) u_outsel (
      .arith_res  (arith_res),
      .logic_res  (logic_res),
      .pick_logic (pick_logic),
      .invert     (invert_out),
      .y          (y_out)
   );
endmodule

// File: tb/tb_nibble_alu.sv
module tb_nibble_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a_in = '0, b_in = '0;
   logic [1:0] arith_op = '0, logic_op = '0;
   logic       pick_logic = 1'b0, invert_out = 1'b0;
   logic [3:0] y_out;
   int         total = 0, bad = 0, cycles = 0;

   always #5 clk = ~clk;

   nibble_alu #(.WIDTH(4)) dut (
      .a_in(a_in), .b_in(b_in), .arith_op(arith_op), .logic_op(logic_op),
      .pick_logic(pick_logic), .invert_out(invert_out), .y_out(y_out)
   );

   function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b,
                                        input logic [1:0] aop, input logic [1:0] lop,
                                        input logic pl, input logic inv);
      logic [4:0] wide;
      logic [3:0] r;
      if (!pl) begin
         case (aop)
            2'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[3:0]; end
            2'd1: begin wide = {1'b0, a} + {1'b0, ~b} + 5'd1; r = wide[3:0]; end
            2'd2: r = (a << 1) | (a >> 3);
            default: r = (a >> 1) | (a << 3);
         endcase
      end else begin
         case (lop)
            2'd0: r = a & b;
            2'd1: r = a | b;
            2'd2: r = a ^ b;
            default: r = ~(a ^ b);
         endcase
      end
      return inv ? ~r : r;
   endfunction

   function automatic string req_of(input logic [1:0] aop, input logic [1:0] lop,
                                    input logic pl, input logic inv);
      if (inv) return "R9";
      if (pl) return (lop < 2) ? "R6" : "R7";
      case (aop)
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] exp);
      total++;
      if (y_out !== exp) begin
         bad++;
         $display("FAIL %s: a=%h b=%h aop=%0d lop=%0d pick=%0b inv=%0b y=%h expected=%h",
                  req, a_in, b_in, arith_op, logic_op, pick_logic, invert_out, y_out, exp);
      end
   endtask

   task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [1:0] aop,
                        input logic [1:0] lop, input logic pl, input logic inv);
      @(posedge clk);
      a_in = a; b_in = b; arith_op = aop; logic_op = lop; pick_logic = pl; invert_out = inv;
      @(negedge clk);
      check(req_of(aop, lop, pl, inv), model(a, b, aop, lop, pl, inv));
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         bad++; total++;
         $display("FAIL R1: watchdog expired y=%h expected=settled run", y_out);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] keep;
      void'($urandom(32'h5EED_0A1F));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", 4'h0);                 // idle state, all-zero inputs

      // R1: input change settles with no clock edge in between
      #1 a_in = 4'h6; b_in = 4'h3;
      #1 check("R1", 4'h9);

      apply(4'hF, 4'h1, 2'd0, 2'd0, 1'b0, 1'b0);   // R2 wrap to 0
      apply(4'h9, 4'h9, 2'd0, 2'd3, 1'b0, 1'b0);   // R2 carry dropped
      apply(4'h0, 4'h1, 2'd1, 2'd0, 1'b0, 1'b0);   // R3 borrow -> F
      apply(4'h5, 4'h7, 2'd1, 2'd0, 1'b0, 1'b0);   // R3
      apply(4'h8, 4'h0, 2'd2, 2'd0, 1'b0, 1'b0);   // R4 top bit -> bit0
      apply(4'hA, 4'h0, 2'd2, 2'd0, 1'b0, 1'b0);   // R4
      apply(4'h1, 4'h0, 2'd3, 2'd0, 1'b0, 1'b0);   // R5 bit0 -> top
      apply(4'h6, 4'h0, 2'd3, 2'd0, 1'b0, 1'b0);   // R5
      apply(4'hC, 4'hA, 2'd0, 2'd0, 1'b1, 1'b0);   // R6 AND
      apply(4'hC, 4'hA, 2'd0, 2'd1, 1'b1, 1'b0);   // R6 OR
      apply(4'hC, 4'hA, 2'd0, 2'd2, 1'b1, 1'b0);   // R7 XOR
      apply(4'hC, 4'hA, 2'd0, 2'd3, 1'b1, 1'b0);   // R7 XNOR
      apply(4'h3, 4'h5, 2'd0, 2'd0, 1'b0, 1'b1);   // R9 inverted add
      apply(4'h3, 4'h5, 2'd0, 2'd2, 1'b1, 1'b1);   // R9 inverted xor

      // R8: the select of the unpicked group must not reach y_out
      apply(4'h7, 4'h4, 2'd0, 2'd0, 1'b0, 1'b0);
      keep = y_out;
      for (int k = 1; k < 4; k++) begin
         @(posedge clk); logic_op = 2'(k);
         @(negedge clk); check("R8", keep);
      end
      apply(4'h7, 4'h4, 2'd0, 2'd2, 1'b1, 1'b0);
      keep = y_out;
      for (int k = 1; k < 4; k++) begin
         @(posedge clk); arith_op = 2'(k);
         @(negedge clk); check("R8", keep);
      end

      for (int n = 0; n < 600; n++) begin
         apply(4'($urandom), 4'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule